// File: doc/BRIEF.md
# Bus Turnaround Wait Inserter

This block sits ahead of an external bus cycle sequencer and decides when the next transfer may start. It protects the shared data bus from a slow device whose read-data driver is still turning off when the next transfer begins. It keeps the area number and the kind of the last access, and counts the empty bus clocks since that access ended. From these it works out, for each new request, how many more idle clocks are needed before the start strobe may be issued.

The wait lengths come from a small bank of 3-bit codes. There is one code per address area and one global code that applies after a single-address DMA transfer in which an I/O device drove the bus. Every code maps to a wait through the fixed, non-linear table given in R5. Empty clocks that have already passed count toward the wait. An arbitration request from another bus master is granted only once the same turnaround has been served.

The sequencer receives a one-clock start pulse together with the area and the direction. It reports the final clock of each access on a done input.

Top module: `bus_turnaround_gate`

## Requirements
- R1: Out of reset the block acts as if the last access was a write. `req_ready` is high, `arb_grant` and `start` are low, and the first request is accepted with no stall cycle.
- R2: After a write access (including one made while another master held the bus), the next request of any area and direction is accepted without stall.
- R3: After a read from area A, a further read from area A that is not a single-address I/O-to-memory DMA is accepted without stall.
- R4: After a read from area A, a write, or a read from a different area, must wait for the number of idle clocks decoded from area A's code. The code of the new request's area plays no part.
- R5: A 3-bit code c selects the wait. Codes 0 to 7 give waits of 0, 1, 2, 3, 4, 6, 10 and 15 clocks respectively.
- R6: Idle clocks that have already passed since the previous access's done cycle are subtracted from the required wait, with a floor of zero. The idle count saturates at 15.
- R7: A request flagged as single-address DMA with the I/O-to-memory direction records the bus as driven by an I/O device. The next request of any area or direction then waits the clocks decoded from the global DMA code.
- R8: Dual-address DMA requests (`req_sadma`=0), and single-address DMA in the memory-to-I/O direction, follow the ordinary per-area rules of R2 to R4 according to `req_write`.
- R9: While `arb_req` is high no request is accepted. `arb_grant` rises one clock after the idle count reaches the wait owed to the last access (0 after a write, per R4 after a read, per R7 after I/O DMA). It stays high while `arb_req` stays high and falls one clock after `arb_req` drops. `start` and `arb_grant` are never high together.
- R10: A config write with `cfg_we`=1 stores `cfg_data` into slot `cfg_slot`. Slots 0 to 6 are the area codes and slot 7 is the global DMA code. Every slot resets to code 7.
- R11: A request is accepted on a clock where `req_valid` and `req_ready` are both high. `start` is high for exactly one clock after acceptance and carries the request's area and write flag. `req_ready` stays low from acceptance until the clock after `seq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config write enable |
| cfg_slot | input | 3 | Config slot: 0-6 area code, 7 DMA code |
| cfg_data | input | 3 | Wait code to store |
| req_valid | input | 1 | Access request pending |
| req_ready | output | 1 | Request may be accepted this clock |
| req_area | input | 3 | Target area, 0 to 6 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sadma | input | 1 | Request is a single-address DMA transfer |
| req_io2mem | input | 1 | DMA direction: I/O device drives memory |
| start | output | 1 | One-clock start strobe to the sequencer |
| start_area | output | 3 | Area of the started access |
| start_write | output | 1 | Direction of the started access |
| seq_done | input | 1 | Final clock of the running access |
| arb_req | input | 1 | Another master requests the bus |
| arb_grant | output | 1 | Bus released to the other master |

## Verification
The assertions take three things for granted about the inputs. `seq_done` is pulsed only while an access is running. `req_area` stays below seven, and request fields are held steady while `req_valid` is high. The bench keeps to this by raising `seq_done` for one clock only after it has seen the start strobe. It drives only legal area numbers, and it changes inputs only on the falling clock edge, keeping a request unchanged until it is accepted. Arbitration is requested only between accesses, never while a request is pending.

// File: rtl/turnaround_pkg.sv
package turnaround_pkg;

  localparam int CODE_W = 3;
  localparam int WAIT_W = 4;

  typedef enum logic [1:0] {
    PK_WRITE = 2'd0,
    PK_READ  = 2'd1,
    PK_DMAIO = 2'd2
  } prev_kind_t;

  // Non-linear code to idle-clock mapping
  function automatic logic [WAIT_W-1:0] decode_wait(input logic [CODE_W-1:0] code);
    logic [WAIT_W-1:0] w;
    case (code)
      3'd0: w = 4'd0;
      3'd1: w = 4'd1;
      3'd2: w = 4'd2;
      3'd3: w = 4'd3;
      3'd4: w = 4'd4;
      3'd5: w = 4'd6;
      3'd6: w = 4'd10;
      default: w = 4'd15;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/tg_cfg_bank.sv
module tg_cfg_bank
  import turnaround_pkg::*;
#(
  parameter int NUM_AREAS = 7,
  parameter int SLOT_W    = $clog2(NUM_AREAS + 1),
  parameter logic [CODE_W-1:0] RST_CODE = 3'd7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [SLOT_W-1:0]             cfg_slot,
  input  logic [CODE_W-1:0]             cfg_data,
  output logic [NUM_AREAS*CODE_W-1:0]   area_codes,
  output logic [CODE_W-1:0]             dma_code
);

  // One register per area slot
  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= RST_CODE;
      end else if (cfg_we && (cfg_slot == SLOT_W'(i))) begin
        code_q <= cfg_data;
      end
    end
    assign area_codes[i*CODE_W +: CODE_W] = code_q;
  end

  // Global slot right after the area slots
  always_ff @(posedge clk) begin
    if (rst) begin
      dma_code <= RST_CODE;
    end else if (cfg_we && (cfg_slot == SLOT_W'(NUM_AREAS))) begin
      dma_code <= cfg_data;
    end
  end

endmodule

// File: rtl/tg_need_calc.sv
module tg_need_calc
  import turnaround_pkg::*;
#(
  parameter int NUM_AREAS = 7,
  parameter int AREA_W    = $clog2(NUM_AREAS)
) (
  input  prev_kind_t                   prev_kind,
  input  logic [AREA_W-1:0]            prev_area,
  input  logic [NUM_AREAS*CODE_W-1:0]  area_codes,
  input  logic [CODE_W-1:0]            dma_code,
  input  logic [AREA_W-1:0]            req_area,
  input  logic                         req_write,
  input  logic                         req_dmaio,
  output logic [WAIT_W-1:0]            req_need,
  output logic [WAIT_W-1:0]            rel_need
);

  logic [WAIT_W-1:0] area_wait [NUM_AREAS];
  logic [WAIT_W-1:0] prev_area_wait;
  logic [WAIT_W-1:0] drive_wait;
  logic              same_read;

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_dec
    assign area_wait[i] = decode_wait(area_codes[i*CODE_W +: CODE_W]);
  end

  always_comb begin
    prev_area_wait = '0;
    for (int i = 0; i < NUM_AREAS; i++) begin
      if (prev_area == AREA_W'(i)) prev_area_wait = area_wait[i];
    end
  end

  // Wait owed to whoever last drove the data bus toward us
  always_comb begin
    case (prev_kind)
      PK_READ:  drive_wait = prev_area_wait;
      PK_DMAIO: drive_wait = decode_wait(dma_code);
      default:  drive_wait = '0;
    endcase
  end

  assign same_read = (prev_kind == PK_READ) && !req_write && !req_dmaio
                     && (req_area == prev_area);
  assign req_need  = same_read ? '0 : drive_wait;
  assign rel_need  = drive_wait;

endmodule

// File: rtl/tg_idle_track.sv
module tg_idle_track
  import turnaround_pkg::*;
#(
  parameter int AREA_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  prev_kind_t         acc_kind,
  input  logic [AREA_W-1:0]  acc_area,
  input  logic               seq_done,
  input  logic               hand_off,
  output prev_kind_t         prev_kind,
  output logic [AREA_W-1:0]  prev_area,
  output logic               in_access,
  output logic [WAIT_W-1:0]  idle_cnt
);

  localparam logic [WAIT_W-1:0] CNT_MAX = {WAIT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_kind <= PK_WRITE;
      prev_area <= '0;
    end else if (accept) begin
      prev_kind <= acc_kind;
      prev_area <= acc_area;
    end else if (hand_off) begin
      prev_kind <= PK_WRITE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_access <= 1'b0;
    end else if (accept) begin
      in_access <= 1'b1;
    end else if (seq_done) begin
      in_access <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
    end else if (accept || seq_done) begin
      idle_cnt <= '0;
    end else if (!in_access && (idle_cnt != CNT_MAX)) begin
      idle_cnt <= idle_cnt + WAIT_W'(1);
    end
  end

  AST_DONE_ONLY_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> in_access); // R11

endmodule

// File: rtl/bus_turnaround_gate.sv
module bus_turnaround_gate
  import turnaround_pkg::*;
#(
  parameter int NUM_AREAS = 7,
  parameter logic [2:0] RST_CODE = 3'd7,
  localparam int AREA_W = $clog2(NUM_AREAS),
  localparam int SLOT_W = $clog2(NUM_AREAS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [2:0]        cfg_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic              req_sadma,
  input  logic              req_io2mem,
  output logic              start,
  output logic [AREA_W-1:0] start_area,
  output logic              start_write,
  input  logic              seq_done,
  input  logic              arb_req,
  output logic              arb_grant
);

  logic [NUM_AREAS*CODE_W-1:0] area_codes;
  logic [CODE_W-1:0]           dma_code;
  prev_kind_t                  prev_kind;
  prev_kind_t                  acc_kind;
  logic [AREA_W-1:0]           prev_area;
  logic                        in_access;
  logic [WAIT_W-1:0]           idle_cnt;
  logic [WAIT_W-1:0]           req_need;
  logic [WAIT_W-1:0]           rel_need;
  logic                        req_dmaio;
  logic                        accept;

  assign req_dmaio = req_sadma && req_io2mem;

  always_comb begin
    if (req_dmaio)      acc_kind = PK_DMAIO;
    else if (req_write) acc_kind = PK_WRITE;
    else                acc_kind = PK_READ;
  end

  tg_cfg_bank #(
    .NUM_AREAS (NUM_AREAS),
    .SLOT_W    (SLOT_W),
    .RST_CODE  (RST_CODE)
  ) cfg_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_slot   (cfg_slot),
    .cfg_data   (cfg_data),
    .area_codes (area_codes),
    .dma_code   (dma_code)
  );

  tg_need_calc #(
    .NUM_AREAS (NUM_AREAS),
    .AREA_W    (AREA_W)
  ) calc_i (
    .prev_kind  (prev_kind),
    .prev_area  (prev_area),
    .area_codes (area_codes),
    .dma_code   (dma_code),
    .req_area   (req_area),
    .req_write  (req_write),
    .req_dmaio  (req_dmaio),
    .req_need   (req_need),
    .rel_need   (rel_need)
  );

  tg_idle_track #(
    .AREA_W (AREA_W)
  ) track_i (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .acc_kind  (acc_kind),
    .acc_area  (req_area),
    .seq_done  (seq_done),
    .hand_off  (arb_grant),
    .prev_kind (prev_kind),
    .prev_area (prev_area),
    .in_access (in_access),
    .idle_cnt  (idle_cnt)
  );

  // Arbitration has priority over new requests
  assign req_ready = !in_access && !arb_grant && !arb_req && (idle_cnt >= req_need);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      arb_grant <= 1'b0;
    end else if (arb_grant) begin
      arb_grant <= arb_req;
    end else begin
      arb_grant <= arb_req && !in_access && (idle_cnt >= rel_need);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start       <= 1'b0;
      start_area  <= '0;
      start_write <= 1'b0;
    end else begin
      start <= accept;
      if (accept) begin
        start_area  <= req_area;
        start_write <= req_write;
      end
    end
  end

  AST_WRITE_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (prev_kind == PK_WRITE) |-> (req_need == '0)); // R2
  AST_SAME_READ_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    ((prev_kind == PK_READ) && !req_write && !req_dmaio && (req_area == prev_area))
      |-> (req_need == '0)); // R3
  AST_GRANT_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_grant) |-> ($past(idle_cnt) >= $past(rel_need))); // R9
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(start && arb_grant)); // R9
  AST_NO_READY_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    in_access |-> !req_ready); // R11
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start |=> !start); // R11

endmodule

// File: tb/bus_turnaround_gate_tb.sv
module bus_turnaround_gate_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_slot = '0;
  logic [2:0] cfg_data = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_area = '0;
  logic       req_write = 1'b0;
  logic       req_sadma = 1'b0;
  logic       req_io2mem = 1'b0;
  logic       start;
  logic [2:0] start_area;
  logic       start_write;
  logic       seq_done = 1'b0;
  logic       arb_req = 1'b0;
  logic       arb_grant;

  int total = 0;
  int bad = 0;

  typedef struct {
    int    area;
    bit    wr;
    int    stall;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  bus_turnaround_gate dut_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_slot    (cfg_slot),
    .cfg_data    (cfg_data),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_area    (req_area),
    .req_write   (req_write),
    .req_sadma   (req_sadma),
    .req_io2mem  (req_io2mem),
    .start       (start),
    .start_area  (start_area),
    .start_write (start_write),
    .seq_done    (seq_done),
    .arb_req     (arb_req),
    .arb_grant   (arb_grant)
  );

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int slot, input int code);
    cfg_we = 1'b1;
    cfg_slot = 3'(slot);
    cfg_data = 3'(code);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: called at the falling edge of the first clock after seq_done
  task automatic do_acc(input int area, input bit wr, input bit sad, input bit io,
                        input int pre_idle, input int stall, input string tag);
    exp_t e;
    repeat (pre_idle) @(negedge clk);
    e.area = area; e.wr = wr; e.stall = stall; e.tag = tag;
    exp_q.push_back(e);
    req_area = 3'(area);
    req_write = wr;
    req_sadma = sad;
    req_io2mem = io;
    req_valid = 1'b1;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(!req_ready, "R11", $sformatf("ready=%0b", req_ready), "ready=0");
    @(negedge clk);
    seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0;
  endtask

  task automatic do_arb(input int exp_cycles, input string tag);
    int n = 0;
    arb_req = 1'b1;
    forever begin
      #1;
      if (arb_grant || n > 40) break;
      n++;
      @(negedge clk);
    end
    chk(n == exp_cycles, tag, $sformatf("grant_after=%0d", n), $sformatf("grant_after=%0d", exp_cycles));
    chk(!req_ready, "R9", $sformatf("ready=%0b", req_ready), "ready=0");
    @(negedge clk);
    chk(arb_grant, "R9", $sformatf("grant=%0b", arb_grant), "grant=1");
    arb_req = 1'b0;
    @(negedge clk);
    #1;
    chk(!arb_grant, "R9", $sformatf("grant=%0b", arb_grant), "grant=0");
  endtask

  // Monitor: count stall clocks and compare each start against the queue
  initial begin
    int stall_cnt = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (rst) begin
        stall_cnt = 0;
        continue;
      end
      if (req_valid && !req_ready) stall_cnt++;
      if (start) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected start", "no start");
        end else begin
          e = exp_q.pop_front();
          chk((int'(start_area) == e.area) && (start_write == e.wr) && (stall_cnt == e.stall), e.tag,
              $sformatf("area=%0d wr=%0b stall=%0d", start_area, start_write, stall_cnt),
              $sformatf("area=%0d wr=%0b stall=%0d", e.area, e.wr, e.stall));
        end
        stall_cnt = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", "timeout", "finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tbl[8] = '{0, 1, 2, 3, 4, 6, 10, 15};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(req_ready && !arb_grant && !start, "R1",
        $sformatf("ready=%0b grant=%0b start=%0b", req_ready, arb_grant, start),
        "ready=1 grant=0 start=0");
    @(negedge clk);
    do_acc(5, 0, 0, 0, 0, 0, "R1");
    do_acc(5, 1, 0, 0, 0, 15, "R10");        // reset code 7 -> 15
    cfg_write(0, 2); cfg_write(1, 5); cfg_write(2, 0); cfg_write(3, 7);
    cfg_write(4, 3); cfg_write(5, 1); cfg_write(6, 3); cfg_write(7, 4);
    do_acc(0, 1, 0, 0, 0, 0, "R2");
    do_acc(0, 0, 0, 0, 0, 0, "R2");
    do_acc(0, 0, 0, 0, 0, 0, "R3");
    do_acc(1, 0, 0, 0, 0, 2, "R4");         // governed by area 0
    do_acc(1, 1, 0, 0, 0, 6, "R4");         // governed by area 1
    for (int c = 0; c < 8; c++) begin
      cfg_write(2, c);
      do_acc(2, 0, 0, 0, 0, 0, "R5");
      do_acc(2, 1, 0, 0, 0, tbl[c], "R5");
    end
    do_acc(3, 0, 0, 0, 0, 0, "R6");
    do_acc(3, 1, 0, 0, 5, 10, "R6");
    do_acc(3, 0, 0, 0, 0, 0, "R6");
    do_acc(3, 1, 0, 0, 20, 0, "R6");
    do_acc(4, 1, 1, 1, 0, 0, "R7");
    do_acc(6, 1, 0, 0, 0, 4, "R7");
    do_acc(4, 1, 1, 1, 0, 0, "R7");
    do_acc(4, 0, 0, 0, 0, 4, "R7");
    do_acc(0, 0, 0, 1, 0, 3, "R8");         // dual-address read, area 4 code
    do_acc(0, 1, 1, 0, 0, 2, "R8");         // memory-to-I/O, area 0 code
    do_acc(1, 0, 0, 0, 0, 0, "R9");
    do_arb(7, "R9");                         // wait 6 plus grant register
    do_acc(1, 1, 0, 0, 0, 0, "R9");
    do_arb(1, "R9");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11", $sformatf("pending=%0d", exp_q.size()), "pending=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule